// File: doc/BRIEF.md
# SDRAM Read Burst Output Model

This block is a synthesizable model of the read side of an SDRAM device. On every rising clock edge it samples the active-low command strobes, the address bus and the bank select. When the strobes encode a READ, it records the bank, the starting column and the auto-precharge flag. After the programmed CAS latency it drives a burst of words onto a DQ bus, which is modelled as a data vector plus an output enable.

The words come from a small on-chip array of registers indexed by bank and column. The array is loaded at reset with a fixed pattern, so every word is known in advance. The burst is either a fixed length of 1, 2, 4 or 8 words, or a full page that runs until it is replaced. A later READ cuts off any burst in progress, and the new data follows the last delivered word with no idle cycle between them. CAS latency and burst length are static configuration inputs, changed only while reset is held.

Top module: `sdram_rd_model`

## Requirements
- R1: A READ is decoded only when sel_ni=0, row_strobe_ni=1, col_strobe_ni=0 and wr_en_ni=1 at a rising edge. Every other combination, including a deselected bus, starts no data.
- R2: For a READ sampled at edge k, the first word is driven with dq_oe_o high in the cycle that follows edge k+CL-1, so it is valid at edge k+CL. CL is 3 when cas_lat3_i=1 and 2 otherwise.
- R3: The word stored at bank b, column c equals ((b << COL_W) | c) XOR FILL. With the defaults (COL_W=4, FILL=8'h5A) this is ((b<<4)|c)^8'h5A. The starting column comes from addr_i[COL_W-1:0] and the bank from ba_i.
- R4: When bl_sel_i[2]=0, bl_sel_i values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. Successive words step the column by one and wrap inside the aligned block of that length.
- R5: When bl_sel_i[2]=1, the burst is a full page. The column increments every cycle, wraps from the last column to column 0, and the burst never ends on its own.
- R6: When no burst word is being delivered, dq_oe_o is 0, dq_o is all zero and pre_o is 0.
- R7: A READ replaces any burst in progress. Its first word appears at its own CAS-latency slot, directly after the last word delivered from the earlier burst. This holds for READs on consecutive cycles.
- R8: A READ with addr_i[10]=1 on a fixed-length burst pulses pre_o for one cycle, with pre_bank_o set to the burst's bank, during the cycle of its last word. A burst cut short by a later READ, or a full-page burst, gives no pulse.
- R9: While rst_ni is low, dq_oe_o and pre_o are 0 and dq_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat3_i | input | 1 | Static: 1 selects CAS latency 3, 0 selects 2 |
| bl_sel_i | input | 3 | Static: bit 2 selects full page; bits 1:0 select a burst of 1, 2, 4 or 8 words |
| sel_ni | input | 1 | Chip select, active low |
| row_strobe_ni | input | 1 | Row strobe, active low |
| col_strobe_ni | input | 1 | Column strobe, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Address bus: low bits carry the column, bit 10 requests auto precharge |
| ba_i | input | BA_W | Bank select |
| dq_o | output | DATA_W | Burst data, zero when not driven |
| dq_oe_o | output | 1 | DQ output enable; low models high impedance |
| pre_o | output | 1 | One-cycle pulse when an auto-precharge burst completes |
| pre_bank_o | output | BA_W | Bank of the completing auto-precharge burst, zero otherwise |

## Verification
A READ sampled at edge k has its first word due in the cycle after edge k+CL-1. Each later word is due one cycle after the one before it. A precharge pulse is due in the same cycle as the last word. The bench drives commands on the falling edge. For each READ it writes the expected output enable, data and precharge values into a table indexed by cycle, starting at the slot of the first word. A later READ clears and rewrites the table from its own first slot, which models truncation. At each falling edge the outputs are compared with the table entry for the cycle that has just begun.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  localparam int MAX_CL = 3;
  localparam int PIPE_D = MAX_CL - 1;
  localparam int CNT_W  = 3;

  typedef enum logic {
    BURST_FIXED = 1'b0,
    BURST_PAGE  = 1'b1
  } burst_mode_e;

  function automatic logic is_read(logic sel_n, logic ras_n, logic cas_n, logic we_n);
    return !sel_n && ras_n && !cas_n && we_n;
  endfunction

  // code 0..3 -> burst of 1,2,4,8 -> in-block offset mask
  function automatic logic [7:0] blk_mask8(logic [1:0] code);
    return 8'((9'd1 << code) - 9'd1);
  endfunction

endpackage

// File: rtl/sdram_rd_cmd_pipe.sv
module sdram_rd_cmd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int COL_W  = 4,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic              wr_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic              cas_lat3_i,
  output logic              launch_vld_o,
  output logic              launch_ap_o,
  output logic [BA_W-1:0]   launch_bank_o,
  output logic [COL_W-1:0]  launch_col_o
);

  typedef struct packed {
    logic             vld;
    logic             ap;
    logic [BA_W-1:0]  bank;
    logic [COL_W-1:0] col;
  } stage_t;

  stage_t pipe_q [PIPE_D];
  stage_t entry;
  stage_t launch;

  logic unused_addr;
  assign unused_addr = ^addr_i;

  always_comb begin
    entry.vld  = is_read(sel_ni, row_strobe_ni, col_strobe_ni, wr_en_ni);
    entry.ap   = addr_i[AP_BIT];
    entry.bank = ba_i;
    entry.col  = addr_i[COL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PIPE_D; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= entry;
      for (int i = 1; i < PIPE_D; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  // stage CL-2 is launched at edge k+CL-1
  generate
    if (PIPE_D > 1) begin : g_sel
      always_comb launch = cas_lat3_i ? pipe_q[MAX_CL-2] : pipe_q[0];
    end else begin : g_fix
      logic unused_cl;
      assign unused_cl = cas_lat3_i;
      always_comb launch = pipe_q[0];
    end
  endgenerate

  assign launch_vld_o  = launch.vld;
  assign launch_ap_o   = launch.ap;
  assign launch_bank_o = launch.bank;
  assign launch_col_o  = launch.col;

endmodule

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq
  import sdram_rd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_vld_i,
  input  logic             launch_ap_i,
  input  logic [BA_W-1:0]  launch_bank_i,
  input  logic [COL_W-1:0] launch_col_i,
  input  logic [1:0]       bl_code_i,
  input  burst_mode_e      mode_i,
  output logic             active_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             ap_o
);

  logic             active_q, ap_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q, col_nxt, mask;
  logic [CNT_W-1:0] cnt_q;

  assign mask = COL_W'(blk_mask8(bl_code_i));

  always_comb begin
    if (mode_i == BURST_PAGE) col_nxt = col_q + 1'b1;
    else                      col_nxt = (col_q & ~mask) | ((col_q + 1'b1) & mask);
  end

  assign last_o = active_q && (mode_i == BURST_FIXED) &&
                  (cnt_q == CNT_W'(blk_mask8(bl_code_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ap_q     <= 1'b0;
      bank_q   <= '0;
      col_q    <= '0;
      cnt_q    <= '0;
    end else if (launch_vld_i) begin
      active_q <= 1'b1;
      ap_q     <= launch_ap_i;
      bank_q   <= launch_bank_i;
      col_q    <= launch_col_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
      end else begin
        col_q <= col_nxt;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign bank_o   = bank_q;
  assign col_o    = col_q;
  assign ap_o     = ap_q;

endmodule

// File: rtl/sdram_rd_store.sv
module sdram_rd_store #(
  parameter int              BA_W   = 2,
  parameter int              COL_W  = 4,
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BA_W-1:0]   rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int NB = 1 << BA_W;
  localparam int NC = 1 << COL_W;

  logic [DATA_W-1:0] mem_q [NB][NC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++)
        for (int c = 0; c < NC; c++)
          mem_q[b][c] <= DATA_W'((b << COL_W) | c) ^ FILL;
    end
  end

  assign rd_data_o = mem_q[rd_bank_i][rd_col_i];

endmodule

// File: rtl/sdram_rd_model.sv
module sdram_rd_model
  import sdram_rd_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter int              BA_W   = 2,
  parameter int              COL_W  = 4,
  parameter int              DATA_W = 8,
  parameter int              AP_BIT = 10,
  parameter logic [DATA_W-1:0] FILL = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cas_lat3_i,
  input  logic [2:0]        bl_sel_i,
  input  logic              sel_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic              wr_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              pre_o,
  output logic [BA_W-1:0]   pre_bank_o
);

  logic              launch_vld, launch_ap;
  logic [BA_W-1:0]   launch_bank, burst_bank;
  logic [COL_W-1:0]  launch_col, burst_col;
  logic              burst_active, burst_last, burst_ap;
  logic [DATA_W-1:0] rd_data;
  burst_mode_e       mode;

  assign mode = bl_sel_i[2] ? BURST_PAGE : BURST_FIXED;

  sdram_rd_cmd_pipe #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_pipe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_ni        (sel_ni),
    .row_strobe_ni (row_strobe_ni),
    .col_strobe_ni (col_strobe_ni),
    .wr_en_ni      (wr_en_ni),
    .addr_i        (addr_i),
    .ba_i          (ba_i),
    .cas_lat3_i    (cas_lat3_i),
    .launch_vld_o  (launch_vld),
    .launch_ap_o   (launch_ap),
    .launch_bank_o (launch_bank),
    .launch_col_o  (launch_col)
  );

  sdram_rd_burst_seq #(
    .BA_W(BA_W), .COL_W(COL_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_vld_i  (launch_vld),
    .launch_ap_i   (launch_ap),
    .launch_bank_i (launch_bank),
    .launch_col_i  (launch_col),
    .bl_code_i     (bl_sel_i[1:0]),
    .mode_i        (mode),
    .active_o      (burst_active),
    .bank_o        (burst_bank),
    .col_o         (burst_col),
    .last_o        (burst_last),
    .ap_o          (burst_ap)
  );

  sdram_rd_store #(
    .BA_W(BA_W), .COL_W(COL_W), .DATA_W(DATA_W), .FILL(FILL)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_bank_i (burst_bank),
    .rd_col_i  (burst_col),
    .rd_data_o (rd_data)
  );

  assign dq_oe_o    = burst_active;
  assign dq_o       = burst_active ? rd_data : '0;
  assign pre_o      = burst_last && burst_ap;
  assign pre_bank_o = pre_o ? burst_bank : '0;

endmodule

// File: rtl/sdram_rd_model_chk.sv
module sdram_rd_model_chk
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cas_lat3_i,
  input logic [2:0]        bl_sel_i,
  input logic              sel_ni,
  input logic              row_strobe_ni,
  input logic              col_strobe_ni,
  input logic              wr_en_ni,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              pre_o,
  input logic              launch_vld_i,
  input logic              burst_active_i,
  input logic [COL_W-1:0]  burst_col_i
);

  logic             rd_seen;
  logic [COL_W-1:0] col_inc, blk_base;

  assign rd_seen  = !sel_ni && row_strobe_ni && !col_strobe_ni && wr_en_ni;
  assign col_inc  = burst_col_i + 1'b1;
  assign blk_base = burst_col_i & ~COL_W'(blk_mask8(bl_sel_i[1:0]));

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0) && !pre_o);

  // R2
  cl2_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_seen && !cas_lat3_i |=> ##1 dq_oe_o);

  // R2
  cl3_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_seen && cas_lat3_i |=> ##2 dq_oe_o);

  // R1
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o && !launch_vld_i |=> !dq_oe_o);

  // R5
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_active_i && !launch_vld_i && bl_sel_i[2] |=> burst_col_i == $past(col_inc));

  // R4
  block_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_active_i && !launch_vld_i && !bl_sel_i[2] |=> $stable(blk_base));

  // R8
  pre_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o && !launch_vld_i |=> !dq_oe_o);

endmodule

bind sdram_rd_model sdram_rd_model_chk #(
  .COL_W(COL_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cas_lat3_i     (cas_lat3_i),
  .bl_sel_i       (bl_sel_i),
  .sel_ni         (sel_ni),
  .row_strobe_ni  (row_strobe_ni),
  .col_strobe_ni  (col_strobe_ni),
  .wr_en_ni       (wr_en_ni),
  .dq_o           (dq_o),
  .dq_oe_o        (dq_oe_o),
  .pre_o          (pre_o),
  .launch_vld_i   (launch_vld),
  .burst_active_i (burst_active),
  .burst_col_i    (burst_col)
);

// File: tb/sdram_rd_model_test.sv
module sdram_rd_model_test;

  localparam int MAXS = 400;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cas_lat3_i = 1'b0;
  logic [2:0]  bl_sel_i = 3'd0;
  logic        sel_ni = 1'b1, row_strobe_ni = 1'b1, col_strobe_ni = 1'b1, wr_en_ni = 1'b1;
  logic [11:0] addr_i = '0;
  logic [1:0]  ba_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe_o, pre_o;
  logic [1:0]  pre_bank_o;

  always #10 clk_i = ~clk_i;

  sdram_rd_model uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cas_lat3_i(cas_lat3_i), .bl_sel_i(bl_sel_i),
    .sel_ni(sel_ni), .row_strobe_ni(row_strobe_ni), .col_strobe_ni(col_strobe_ni),
    .wr_en_ni(wr_en_ni), .addr_i(addr_i), .ba_i(ba_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .pre_o(pre_o), .pre_bank_o(pre_bank_o)
  );

  int    vectors = 0, errors = 0;
  bit    done = 0;
  int    s, cl;
  string tag;
  logic       exp_oe  [MAXS];
  logic [7:0] exp_dq  [MAXS];
  logic       exp_pre [MAXS];
  logic [1:0] exp_pb  [MAXS];

  // R3 stored pattern
  function automatic logic [7:0] word(int b, int c);
    return 8'((b << 4) | c) ^ 8'h5A;
  endfunction

  task automatic check_slot();
    if (s < 0 || s >= MAXS) return;
    vectors++;
    if (dq_oe_o !== exp_oe[s] || dq_o !== exp_dq[s] ||
        pre_o !== exp_pre[s] || pre_bank_o !== exp_pb[s]) begin
      errors++;
      $display("FAIL %s slot %0d oe=%b/%b dq=%h/%h pre=%b/%b bank=%0d/%0d",
               (pre_o !== exp_pre[s]) ? "R8" : tag, s, dq_oe_o, exp_oe[s],
               dq_o, exp_dq[s], pre_o, exp_pre[s], pre_bank_o, exp_pb[s]);
    end
  endtask

  // expected per-slot output for a READ sampled at edge k (R2, R4, R5, R7, R8)
  task automatic plan(int k, int b, int c, bit ap);
    int first = k + cl - 1;
    for (int j = first; j < MAXS; j++) begin
      exp_oe[j] = 0; exp_dq[j] = '0; exp_pre[j] = 0; exp_pb[j] = '0;
    end
    if (bl_sel_i[2]) begin
      for (int j = first; j < MAXS; j++) begin
        exp_oe[j] = 1;
        exp_dq[j] = word(b, (c + j - first) & 15);
      end
    end else begin
      int bl = 1 << bl_sel_i[1:0];
      int base = c & ~(bl - 1);
      for (int j = 0; j < bl; j++) begin
        if (first + j < MAXS) begin
          exp_oe[first+j] = 1;
          exp_dq[first+j] = word(b, base | ((c + j) & (bl - 1)));
          if (j == bl - 1 && ap) begin
            exp_pre[first+j] = 1;
            exp_pb[first+j]  = 2'(b);
          end
        end
      end
    end
  endtask

  task automatic drive_other();
    logic [3:0] p = 4'($urandom_range(15));
    if (p == 4'b0101) p = 4'b0100;
    {sel_ni, row_strobe_ni, col_strobe_ni, wr_en_ni} = p;
    addr_i = 12'($urandom);
    ba_i   = 2'($urandom_range(3));
  endtask

  task automatic step(bit rd, int b, int c, bit ap);
    @(negedge clk_i);
    s++;
    check_slot();
    if (rd) begin
      {sel_ni, row_strobe_ni, col_strobe_ni, wr_en_ni} = 4'b0101;
      addr_i = 12'($urandom);
      addr_i[3:0] = 4'(c);
      addr_i[10]  = ap;
      ba_i = 2'(b);
      plan(s + 1, b, c, ap);
    end else begin
      drive_other();
    end
  endtask

  task automatic idle(int n);
    repeat (n) step(0, 0, 0, 0);
  endtask

  task automatic rand_run(int n, int pct);
    repeat (n) step($urandom_range(99) < pct, $urandom_range(3), $urandom_range(15),
                    1'($urandom_range(1)));
  endtask

  task automatic phase(bit c3, logic [2:0] sel);
    @(negedge clk_i);
    rst_ni = 0;
    {sel_ni, row_strobe_ni, col_strobe_ni, wr_en_ni} = 4'b1111;
    cas_lat3_i = c3;
    bl_sel_i   = sel;
    cl = c3 ? 3 : 2;
    for (int j = 0; j < MAXS; j++) begin
      exp_oe[j] = 0; exp_dq[j] = '0; exp_pre[j] = 0; exp_pb[j] = '0;
    end
    repeat (2) begin
      @(negedge clk_i);
      vectors++;
      if (dq_oe_o !== 1'b0 || pre_o !== 1'b0 || dq_o !== '0) begin
        errors++;
        $display("FAIL R9 reset oe=%b/0 pre=%b/0 dq=%h/00", dq_oe_o, pre_o, dq_o);
      end
    end
    rst_ni = 1;
    s = -1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    // CL2, burst of 4: block wrap and precharge pulse (R4, R8), then quiet bus (R6)
    phase(1'b0, 3'd2);
    tag = "R4";
    step(1, 1, 5, 1);
    tag = "R6";
    idle(8);
    tag = "R4";
    step(1, 3, 2, 0);
    idle(6);
    tag = "R3";
    rand_run(220, 25);
    idle(12);

    // CL3, burst of 8: truncation drops the pulse and output stays continuous (R7)
    phase(1'b1, 3'd3);
    tag = "R7";
    step(1, 2, 9, 1);
    idle(3);
    step(1, 0, 15, 1);
    idle(12);
    rand_run(220, 30);
    idle(12);

    // CL2, burst of 1: READs on consecutive cycles (R2, R7)
    phase(1'b0, 3'd0);
    tag = "R2";
    for (int i = 0; i < 5; i++) step(1, i & 3, 3 * i, 1);
    idle(6);
    rand_run(150, 40);
    idle(10);

    // CL3, full page: wraps past the last column, cut only by a new READ (R5)
    phase(1'b1, 3'd4);
    tag = "R5";
    step(1, 3, 14, 1);
    idle(20);
    step(1, 1, 0, 0);
    idle(10);
    rand_run(100, 5);

    // CL2, burst of 2: other strobe codes start nothing (R1)
    phase(1'b0, 3'd1);
    tag = "R1";
    idle(10);
    rand_run(200, 10);
    idle(10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at slot %0d", s);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule